// File: doc/BRIEF.md
# Dual-Issue Dispatch and Repeat-Loop Sequencer

This block sits between instruction fetch and the two execution units of a dual-issue core. Each cycle in which `step` is high, it looks at the 64-bit word fetched at the current program counter. It decides whether the word is one long instruction or a pair of 32-bit short slots. For a pair, it also decides which slot goes first, which unit each slot uses, and whether the second slot runs. The slot units report branch-taken, target and kill signals in the same cycle. The block merges these into one branch decision.

The block owns the program counter, a zero-overhead repeat loop and the status word. The repeat loop is made of a start address, an end address, a 32-bit iteration count and a repeat-active status bit. The block samples and decrements the count before the step, ends the loop when the count runs out, and chooses the next PC from branch, loop-back and fall-through. An instruction-address breakpoint, enabled by a status bit, then overrides that choice. It saves the chosen PC and the status word to debug registers and jumps to a fixed debug vector.

Software loads the loop registers, the status word and the PC through a simple write port.

Top module: `issue_seq`

## Requirements
- R1: The format code is {word[63], word[31]}. Code 0 is a parallel pair, 1 is left slot then right slot, 2 is right slot then left slot, and 3 is one long instruction.
- R2: Unit codes are 0 memory, 1 integer, 2 any. For code 1 the first slot is the left one (`slot_a_right`=0) on the memory unit. For code 2 the first slot is the right one (`slot_a_right`=1) on the integer unit. In both sequential cases the second slot uses unit 2. A long instruction uses the left slot signals, reports unit 2 for both slots and never runs a second slot.
- R3: In a sequential pair, the second slot runs only when the first slot neither branched nor asserted kill. A branch by the second slot counts only when it ran.
- R4: In a parallel pair, both slots run: left on the memory unit, right on the integer unit, and kill is ignored. If exactly one slot branches, its target is taken. If both branch, `dual_branch_err` is raised and neither target is used.
- R5: Before a step, the block tests whether the count is nonzero. At the loop end address, the count drops by one if it is nonzero or the repeat bit is set. It never goes below zero.
- R6: When the step is at the loop end with the repeat bit set and the count after decrement is zero, the repeat bit (status bit 4) is cleared.
- R7: The next PC is the taken branch target if there is one. Otherwise it is the loop start, when the repeat bit was set, the sampled count was nonzero and the PC equals the loop end. Otherwise it is PC+8.
- R8: A step at PC equal to `bkpt_addr` with status bit 2 set is a breakpoint hit. It saves the R7 PC in `dbg_pc`, and saves the post-loop status with bit 1 set in `dbg_status`. It keeps only bit 0 of the status, then sets bit 3, and loads PC 0xFFFFF128.
- R9: A write with `cfg_we` updates the register picked by `cfg_sel` (0 loop start, 1 loop end, 2 count, 3 status, 4 PC) at the next clock edge. A write overrides a step's update to the same register. With neither a step nor a write, all state holds.
- R10: After reset, the PC is 0 and the loop registers, count, status and debug registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Execute the fetched word this cycle |
| fetch_word | input | 64 | Word fetched at the current PC |
| l_br | input | 1 | Left slot (or long instruction) branch taken |
| l_tgt | input | 32 | Left slot branch target |
| l_kill | input | 1 | Left slot kills the following slot |
| r_br | input | 1 | Right slot branch taken |
| r_tgt | input | 32 | Right slot branch target |
| r_kill | input | 1 | Right slot kills the following slot |
| bkpt_addr | input | 32 | Instruction breakpoint address |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_data | input | 32 | Write data |
| issue_fmt | output | 2 | Format code of the fetched word |
| slot_a_right | output | 1 | First slot is the right slot |
| slot_a_unit | output | 2 | Unit code of the first slot |
| slot_b_unit | output | 2 | Unit code of the second slot |
| slot_b_run | output | 1 | Second slot executes |
| dual_branch_err | output | 1 | Both parallel slots branched |
| next_pc | output | 32 | PC that this step will load |
| pc | output | 32 | Current program counter |
| loop_count | output | 32 | Repeat iteration count |
| status | output | 32 | Status word |
| dbg_pc | output | 32 | Saved PC of the last breakpoint hit |
| dbg_status | output | 32 | Saved status of the last breakpoint hit |

## Verification
The bench builds the block with its default parameters: 32-bit slots and registers, a stride of 8 and the fixed debug vector. Because the count register is a plain 32-bit register, the bench can load small counts of 0, 1, 2 and 3. That brings loop exit, the saturating count at zero and the repeat-bit clear within a handful of steps. The same short loop also reaches the clash of a branch with loop-back at the end address, and a breakpoint hit at the loop end that must save the loop start.

// File: rtl/issue_seq_pkg.sv
package issue_seq_pkg;
  typedef enum logic [1:0] {
    FMT_PAR  = 2'd0,
    FMT_LR   = 2'd1,
    FMT_RL   = 2'd2,
    FMT_LONG = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    U_MEM = 2'd0,
    U_INT = 2'd1,
    U_ANY = 2'd2
  } unit_e;

  // Format bits sit at the top of each half of the fetched word.
  function automatic fmt_e classify(input logic hi_bit, input logic lo_bit);
    return fmt_e'({hi_bit, lo_bit});
  endfunction

  // Count decrement that stops at zero.
  function automatic logic [31:0] sat_dec(input logic [31:0] v);
    return (v == 32'd0) ? 32'd0 : v - 32'd1;
  endfunction
endpackage

// File: rtl/issue_decode.sv
module issue_decode
  import issue_seq_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int XLEN   = 32,
  localparam int WORD_W = 2 * SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              l_br,
  input  logic [XLEN-1:0]   l_tgt,
  input  logic              l_kill,
  input  logic              r_br,
  input  logic [XLEN-1:0]   r_tgt,
  input  logic              r_kill,
  output fmt_e              fmt,
  output logic              a_right,
  output unit_e             a_unit,
  output unit_e             b_unit,
  output logic              b_run,
  output logic              br_taken,
  output logic [XLEN-1:0]   br_tgt,
  output logic              dual_err
);
  assign fmt = classify(word[WORD_W-1], word[SLOT_W-1]);

  always_comb begin
    a_right  = 1'b0;
    a_unit   = U_ANY;
    b_unit   = U_ANY;
    b_run    = 1'b0;
    br_taken = 1'b0;
    br_tgt   = l_tgt;
    dual_err = 1'b0;
    unique case (fmt)
      FMT_LONG: begin
        br_taken = l_br;
      end
      FMT_LR: begin
        a_unit   = U_MEM;
        b_run    = !l_br && !l_kill;
        br_taken = l_br || (b_run && r_br);
        br_tgt   = l_br ? l_tgt : r_tgt;
      end
      FMT_RL: begin
        a_right  = 1'b1;
        a_unit   = U_INT;
        b_run    = !r_br && !r_kill;
        br_taken = r_br || (b_run && l_br);
        br_tgt   = r_br ? r_tgt : l_tgt;
      end
      default: begin
        a_unit   = U_MEM;
        b_unit   = U_INT;
        b_run    = 1'b1;
        dual_err = l_br && r_br;
        br_taken = l_br ^ r_br;
        br_tgt   = l_br ? l_tgt : r_tgt;
      end
    endcase
  end

  // R3: second slot of a left-first pair only after a quiet left slot
  a_r3_lr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_LR && b_run) |-> (!l_br && !l_kill));
  // R3: second slot of a right-first pair only after a quiet right slot
  a_r3_rl_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_RL && b_run) |-> (!r_br && !r_kill));
  // R4: the double-branch error belongs to parallel pairs and blocks the branch
  a_r4_err_par: assert property (@(posedge clk) disable iff (!rst_n)
    dual_err |-> (fmt == FMT_PAR && !br_taken));
  // R2: a long instruction never runs a second slot
  a_r2_long_single: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_LONG) |-> !b_run);
endmodule

// File: rtl/loop_ctrl.sv
module loop_ctrl
  import issue_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] loop_end,
  input  logic [31:0]     count,
  input  logic            rp,
  output logic            at_end,
  output logic            loop_back,
  output logic [31:0]     cnt_next,
  output logic            rp_next
);
  logic was_nz;
  logic dec;

  assign at_end    = (pc == loop_end);
  assign was_nz    = (count != 32'd0);
  assign dec       = at_end && (was_nz || rp);
  assign cnt_next  = dec ? sat_dec(count) : count;
  assign rp_next   = rp && !(at_end && cnt_next == 32'd0);
  assign loop_back = rp && was_nz && at_end;
endmodule

// File: rtl/issue_seq.sv
module issue_seq
  import issue_seq_pkg::*;
#(
  parameter int              SLOT_W   = 32,
  parameter int              XLEN     = 32,
  parameter int              STRIDE   = 8,
  parameter logic [31:0]     DBG_VEC  = 32'hFFFF_F128,
  parameter logic [31:0]     RESET_PC = 32'h0,
  parameter int              BIT_SM   = 0,
  parameter int              BIT_EA   = 1,
  parameter int              BIT_DB   = 2,
  parameter int              BIT_DS   = 3,
  parameter int              BIT_RP   = 4,
  localparam int             WORD_W   = 2 * SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              l_br,
  input  logic [XLEN-1:0]   l_tgt,
  input  logic              l_kill,
  input  logic              r_br,
  input  logic [XLEN-1:0]   r_tgt,
  input  logic              r_kill,
  input  logic [XLEN-1:0]   bkpt_addr,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [XLEN-1:0]   cfg_data,
  output logic [1:0]        issue_fmt,
  output logic              slot_a_right,
  output logic [1:0]        slot_a_unit,
  output logic [1:0]        slot_b_unit,
  output logic              slot_b_run,
  output logic              dual_branch_err,
  output logic [XLEN-1:0]   next_pc,
  output logic [XLEN-1:0]   pc,
  output logic [31:0]       loop_count,
  output logic [XLEN-1:0]   status,
  output logic [XLEN-1:0]   dbg_pc,
  output logic [XLEN-1:0]   dbg_status
);
  localparam logic [XLEN-1:0] SM_M = XLEN'(1) << BIT_SM;
  localparam logic [XLEN-1:0] EA_M = XLEN'(1) << BIT_EA;
  localparam logic [XLEN-1:0] DS_M = XLEN'(1) << BIT_DS;
  localparam logic [2:0] SEL_START = 3'd0;
  localparam logic [2:0] SEL_END   = 3'd1;
  localparam logic [2:0] SEL_CNT   = 3'd2;
  localparam logic [2:0] SEL_STAT  = 3'd3;
  localparam logic [2:0] SEL_PC    = 3'd4;

  logic [XLEN-1:0] pc_q, start_q, end_q, psw_q, dpc_q, dpsw_q;
  logic [31:0]     cnt_q;

  fmt_e            fmt;
  unit_e           a_unit, b_unit;
  logic            br_taken;
  logic [XLEN-1:0] br_tgt;
  logic            at_end, loop_back, rp_nx;
  logic [31:0]     cnt_nx;
  logic [XLEN-1:0] seq_pc, psw_lp;
  logic            bk_hit;

  issue_decode #(.SLOT_W(SLOT_W), .XLEN(XLEN)) dec_i (
    .clk(clk), .rst_n(rst_n), .word(fetch_word),
    .l_br(l_br), .l_tgt(l_tgt), .l_kill(l_kill),
    .r_br(r_br), .r_tgt(r_tgt), .r_kill(r_kill),
    .fmt(fmt), .a_right(slot_a_right), .a_unit(a_unit), .b_unit(b_unit),
    .b_run(slot_b_run), .br_taken(br_taken), .br_tgt(br_tgt),
    .dual_err(dual_branch_err)
  );

  loop_ctrl #(.XLEN(XLEN)) loop_i (
    .pc(pc_q), .loop_end(end_q), .count(cnt_q), .rp(psw_q[BIT_RP]),
    .at_end(at_end), .loop_back(loop_back), .cnt_next(cnt_nx), .rp_next(rp_nx)
  );

  always_comb begin
    psw_lp         = psw_q;
    psw_lp[BIT_RP] = rp_nx;
  end

  assign seq_pc  = br_taken ? br_tgt : (loop_back ? start_q : pc_q + XLEN'(STRIDE));
  assign bk_hit  = (pc_q == bkpt_addr) && psw_q[BIT_DB];
  assign next_pc = bk_hit ? DBG_VEC : seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
      psw_q   <= '0;
      dpc_q   <= '0;
      dpsw_q  <= '0;
    end else begin
      if (step) begin
        cnt_q <= cnt_nx;
        if (bk_hit) begin
          dpc_q  <= seq_pc;
          dpsw_q <= psw_lp | EA_M;
          psw_q  <= (psw_lp & SM_M) | DS_M;
          pc_q   <= DBG_VEC;
        end else begin
          psw_q <= psw_lp;
          pc_q  <= seq_pc;
        end
      end
      if (cfg_we) begin
        case (cfg_sel)
          SEL_START: start_q <= cfg_data;
          SEL_END:   end_q   <= cfg_data;
          SEL_CNT:   cnt_q   <= 32'(cfg_data);
          SEL_STAT:  psw_q   <= cfg_data;
          SEL_PC:    pc_q    <= cfg_data;
          default:   ;
        endcase
      end
    end
  end

  assign issue_fmt   = fmt;
  assign slot_a_unit = a_unit;
  assign slot_b_unit = b_unit;
  assign pc          = pc_q;
  assign loop_count  = cnt_q;
  assign status      = psw_q;
  assign dbg_pc      = dpc_q;
  assign dbg_status  = dpsw_q;

  // R5: a step moves the count down by at most one
  a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cfg_we) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 32'd1));
  // R5: a zero count stays at zero
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cfg_we && cnt_q == 32'd0) |=> (cnt_q == 32'd0));
  // R6: a loop that runs out at its end leaves the repeat bit clear
  a_r6_rp_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cfg_we && at_end && cnt_q <= 32'd1) |=> !psw_q[BIT_RP]);
  // R8: a breakpoint hit lands on the debug vector with the debug-state bit set
  a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cfg_we && bk_hit) |=> (pc_q == DBG_VEC && psw_q[BIT_DS] && !psw_q[BIT_DB]));
  // R9: with no step and no write, the state holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cfg_we) |=> ($stable(pc_q) && $stable(cnt_q) && $stable(psw_q)));
endmodule

// File: tb/issue_seq_tb.sv
module issue_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [63:0] fetch_word = '0;
  logic        l_br = 1'b0, l_kill = 1'b0, r_br = 1'b0, r_kill = 1'b0;
  logic [31:0] l_tgt = '0, r_tgt = '0;
  logic [31:0] bkpt_addr = 32'hFFFF_FFF0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic [1:0]  issue_fmt, slot_a_unit, slot_b_unit;
  logic        slot_a_right, slot_b_run, dual_branch_err;
  logic [31:0] next_pc, pc, loop_count, status, dbg_pc, dbg_status;

  issue_seq dut_i (
    .clk(clk), .rst_n(rst_n), .step(step), .fetch_word(fetch_word),
    .l_br(l_br), .l_tgt(l_tgt), .l_kill(l_kill),
    .r_br(r_br), .r_tgt(r_tgt), .r_kill(r_kill),
    .bkpt_addr(bkpt_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .issue_fmt(issue_fmt), .slot_a_right(slot_a_right), .slot_a_unit(slot_a_unit),
    .slot_b_unit(slot_b_unit), .slot_b_run(slot_b_run),
    .dual_branch_err(dual_branch_err), .next_pc(next_pc), .pc(pc),
    .loop_count(loop_count), .status(status), .dbg_pc(dbg_pc), .dbg_status(dbg_status)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    int          due;
    logic [31:0] pc, cnt, psw, dpc, dpsw;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  logic [31:0] m_pc = 0, m_start = 0, m_end = 0, m_cnt = 0, m_psw = 0, m_dpc = 0, m_dpsw = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: compares registered state once the expected item is due.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.req, "pc", pc, e.pc);
      chk(e.req, "count", loop_count, e.cnt);
      chk(e.req, "status", status, e.psw);
      chk(e.req, "dbg_pc", dbg_pc, e.dpc);
      chk(e.req, "dbg_status", dbg_status, e.dpsw);
    end
  end

  task automatic push_exp(input string req);
    exp_t e;
    e.due = cyc + 1; e.pc = m_pc; e.cnt = m_cnt; e.psw = m_psw;
    e.dpc = m_dpc; e.dpsw = m_dpsw; e.req = req;
    sb.push_back(e);
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    case (sel)
      3'd0: m_start = d;
      3'd1: m_end = d;
      3'd2: m_cnt = d;
      3'd3: m_psw = d;
      default: m_pc = d;
    endcase
    push_exp("R9");
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      push_exp("R9");
      @(negedge clk);
    end
  endtask

  task automatic run_step(input logic [63:0] w, input logic lb, input logic [31:0] lt, input logic lk,
                          input logic rb, input logic [31:0] rt, input logic rk, input string req);
    logic [1:0]  fm, e_au, e_bu;
    logic        e_ar, e_brun, e_err, tk, end_hit, nz, rpb;
    logic [31:0] tg, np;
    fetch_word = w; l_br = lb; l_tgt = lt; l_kill = lk; r_br = rb; r_tgt = rt; r_kill = rk;
    step = 1'b1;
    fm = {w[63], w[31]};
    e_err = 1'b0; tk = 1'b0; tg = 32'h0;
    case (fm)
      2'd3: begin e_ar = 0; e_au = 2; e_bu = 2; e_brun = 0; tk = lb; tg = lt; end
      2'd1: begin
        e_ar = 0; e_au = 0; e_bu = 2; e_brun = !(lb || lk);
        if (lb) begin tk = 1; tg = lt; end else if (e_brun && rb) begin tk = 1; tg = rt; end
      end
      2'd2: begin
        e_ar = 1; e_au = 1; e_bu = 2; e_brun = !(rb || rk);
        if (rb) begin tk = 1; tg = rt; end else if (e_brun && lb) begin tk = 1; tg = lt; end
      end
      default: begin
        e_ar = 0; e_au = 0; e_bu = 1; e_brun = 1; e_err = lb && rb;
        if (lb && !rb) begin tk = 1; tg = lt; end
        if (rb && !lb) begin tk = 1; tg = rt; end
      end
    endcase
    end_hit = (m_pc == m_end); nz = (m_cnt != 0); rpb = m_psw[4];
    if (end_hit && nz) m_cnt = m_cnt - 1;
    if (rpb && end_hit && m_cnt == 0) m_psw[4] = 1'b0;
    if (tk) np = tg;
    else if (rpb && nz && end_hit) np = m_start;
    else np = m_pc + 32'd8;
    if (m_pc == bkpt_addr && m_psw[2]) begin
      m_dpc = np; m_dpsw = m_psw | 32'h2; m_psw = (m_psw & 32'h1) | 32'h8; np = 32'hFFFF_F128;
    end
    #1;
    chk("R1", "fmt", {30'd0, issue_fmt}, {30'd0, fm});
    chk("R2", "a_right", {31'd0, slot_a_right}, {31'd0, e_ar});
    chk("R2", "a_unit", {30'd0, slot_a_unit}, {30'd0, e_au});
    chk("R2", "b_unit", {30'd0, slot_b_unit}, {30'd0, e_bu});
    chk("R3", "b_run", {31'd0, slot_b_run}, {31'd0, e_brun});
    chk("R4", "dual_err", {31'd0, dual_branch_err}, {31'd0, e_err});
    chk(req, "next_pc", next_pc, np);
    m_pc = np;
    push_exp(req);
    @(negedge clk);
    step = 1'b0; l_br = 0; r_br = 0; l_kill = 0; r_kill = 0;
  endtask

  localparam logic [63:0] W_PAR  = 64'h0000_0000_0000_0000;
  localparam logic [63:0] W_LR   = 64'h0000_0000_8000_0000;
  localparam logic [63:0] W_RL   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] W_LONG = 64'h8000_0000_8000_0000;

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "pc", pc, 32'h0);
    chk("R10", "count", loop_count, 32'h0);
    chk("R10", "status", status, 32'h0);
    chk("R10", "dbg_pc", dbg_pc, 32'h0);

    // R1/R2: long and sequential decode, no branches
    run_step(W_LONG, 0, 0, 0, 0, 0, 0, "R7");
    run_step(W_LR, 0, 0, 0, 0, 0, 0, "R7");
    // R3: kill from first slot suppresses the second
    run_step(W_LR, 0, 0, 1, 1, 32'h500, 0, "R3");
    run_step(W_RL, 0, 32'h40, 0, 1, 32'h200, 0, "R3");
    run_step(W_RL, 1, 32'h40, 0, 0, 0, 0, "R3");
    run_step(W_LR, 0, 0, 0, 1, 32'h300, 0, "R3");
    // R4: parallel pairs
    run_step(W_PAR, 1, 32'h80, 1, 0, 0, 1, "R4");
    run_step(W_PAR, 0, 0, 0, 1, 32'h90, 0, "R4");
    run_step(W_PAR, 1, 32'h700, 0, 1, 32'h800, 0, "R4");
    idle(3);

    // R5/R6/R7: two-count repeat loop over 0x100..0x110
    cfg(3'd0, 32'h100); cfg(3'd1, 32'h110); cfg(3'd2, 32'd2);
    cfg(3'd3, 32'h10); cfg(3'd4, 32'h100);
    for (int i = 0; i < 9; i++) run_step(W_LONG, 0, 0, 0, 0, 0, 0, "R5");
    // R7: branch beats loop-back at end
    cfg(3'd2, 32'd1); cfg(3'd3, 32'h10); cfg(3'd4, 32'h110);
    run_step(W_LONG, 1, 32'h400, 0, 0, 0, 0, "R7");
    // R5/R6: zero count with repeat bit at end
    cfg(3'd2, 32'd0); cfg(3'd3, 32'h10); cfg(3'd4, 32'h110);
    run_step(W_LONG, 0, 0, 0, 0, 0, 0, "R6");
    // R5: nonzero count, repeat bit clear, at end
    cfg(3'd2, 32'd3); cfg(3'd3, 32'h0); cfg(3'd4, 32'h110);
    run_step(W_LONG, 0, 0, 0, 0, 0, 0, "R5");

    // R8: breakpoint mid-loop
    cfg(3'd2, 32'd5); cfg(3'd3, 32'h95); cfg(3'd4, 32'h108);
    bkpt_addr = 32'h108;
    run_step(W_LONG, 0, 0, 0, 0, 0, 0, "R8");
    // R8: breakpoint address match with enable bit clear
    cfg(3'd4, 32'h108);
    run_step(W_LONG, 0, 0, 0, 0, 0, 0, "R8");
    // R8: breakpoint at loop end saves loop start
    cfg(3'd2, 32'd2); cfg(3'd3, 32'h14); cfg(3'd4, 32'h110);
    bkpt_addr = 32'h110;
    run_step(W_LONG, 0, 0, 0, 0, 0, 0, "R8");
    bkpt_addr = 32'hFFFF_FFF0;
    idle(2);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule